// File: doc/BRIEF.md
# Secondary-Side Data Parity Error Reaction Controller

This block sits on the secondary side of a two-port bus bridge. For every transfer it receives, it decides how the bridge reacts to a data parity problem seen on the secondary bus. Each transfer is described by:

- its class: posted write, delayed write, delayed read, or access to the bridge's own registers;
- its direction;
- whether bad data parity was detected, and whether the secondary parity-error line was seen asserted by the far target;
- whether the primary side had its own parity error;
- whether more than one data phase was requested.

Two enable bits, one for each side's parity-error response, gate the reactions.

The decision outputs are combinational and valid while the event is presented:

- complete or forward the transfer, or drop it;
- request a target response (ready, plus stop for bursts);
- poison the returned or forwarded data so that it keeps bad parity.

Two sticky status bits record what was seen. Requests to drive the parity-error and system-error lines go out as registered, active-low, single-cycle pulses.

The primary parity-error request for a downstream delayed write must line up with the moment the bridge hands the ready response back to the primary initiator. A two-state machine covers this:

- `TF_IDLE`: nothing is pending.
- `TF_IDLE` to `TF_HOLD`: a qualifying event arms the machine.
- `TF_HOLD`: the machine waits for the ready-return strobe.
- `TF_HOLD` to `TF_IDLE`: the strobe fires the request and the machine returns to idle.
- `TF_HOLD` to `TF_HOLD`: the strobe and a new arming event arrive in the same cycle, so the machine fires and stays armed.

Top module: `parity_resp_ctl`

## Requirements
- R1: After reset both status bits are 0, all three request outputs are 1 (idle), and all decision outputs are 0.
- R2: While `evt_valid` is 0, all decision outputs are 0, no status bit is set and no request pulse is produced.
- R3: Downstream posted write (`evt_kind`=0, `evt_up`=0): `xfer_go`=1. If the secondary enable is set and `sec_perr_n`=0, the data-parity status bit (`sts_w1c` bit 0) is set. If both enables are also set and `pri_par_err`=0, a primary system-error pulse is requested.
- R4: Upstream posted write with `evt_bad_par`=1: `xfer_go`=1 and `data_poison`=1. The detected-parity status bit (`sts_w1c` bit 1) is set. A secondary parity-error pulse is requested only when the secondary enable is set.
- R5: Downstream delayed write (`evt_kind`=1, `evt_up`=0): `xfer_go`=1, and the data-parity status bit is set as in R3. If both enables are set and `sec_perr_n`=0, the controller enters `TF_HOLD` from the next cycle. The first `pri_trdy_ret`=1 sampled in `TF_HOLD` drives `pri_perr_req_n` low for exactly the following cycle.
- R6: Upstream delayed write with `evt_bad_par`=1: with the secondary enable clear, the transfer completes normally with no error action. With the secondary enable set, `xfer_drop`=1, `xfer_go`=0, `tgt_trdy`=1 and `tgt_stop`=`evt_burst`, the detected-parity bit is set, and a secondary parity-error pulse is requested.
- R7: Downstream delayed read (`evt_kind`=2, `evt_up`=0) with `evt_bad_par`=1: `xfer_go`=1, `data_poison`=1, and the detected-parity bit is set. If the secondary enable is set, the data-parity bit is also set and a secondary parity-error pulse is requested.
- R8: An upstream delayed read, or a register read (`evt_kind`=3, `evt_write`=0), only completes (`xfer_go`=1), with no status or pulse.
- R9: Register write (`evt_kind`=3, `evt_write`=1) with `evt_bad_par`=1: `xfer_go`=1, and the detected-parity bit is set. A secondary parity-error pulse is requested only when the secondary enable is set.
- R10: Status bits are sticky. Writing 1 to a `sts_w1c` bit clears it on the next edge. A set in the same cycle wins over the clear.
- R11: Secondary parity-error and primary system-error requests go low during the cycle after the edge that sampled the triggering event, and stay low for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | A transfer event is presented this cycle |
| evt_kind | input | 2 | Class: 0 posted write, 1 delayed write, 2 delayed read, 3 register access |
| evt_up | input | 1 | 1 upstream, 0 downstream |
| evt_write | input | 1 | Register access is a write (register class only) |
| evt_bad_par | input | 1 | Bad data parity detected on the secondary bus |
| evt_burst | input | 1 | More than one data phase requested |
| sec_perr_n | input | 1 | Sampled secondary parity-error line, active low |
| pri_par_err | input | 1 | Primary side detected its own parity error |
| per_en_pri | input | 1 | Primary parity-error response enable |
| per_en_sec | input | 1 | Secondary parity-error response enable |
| pri_trdy_ret | input | 1 | Ready being returned to the primary initiator |
| sts_w1c | input | 2 | Write-one-to-clear strobes: bit 0 data-parity, bit 1 detected-parity |
| sts_dpd | output | 1 | Sticky data-parity-detected status |
| sts_dpe | output | 1 | Sticky detected-parity-error status |
| sec_perr_req_n | output | 1 | Secondary parity-error pulse request, active low |
| pri_perr_req_n | output | 1 | Primary parity-error pulse request, active low |
| pri_serr_req_n | output | 1 | Primary system-error pulse request, active low |
| xfer_go | output | 1 | Complete or forward the transfer |
| xfer_drop | output | 1 | Discard the transfer |
| tgt_trdy | output | 1 | Request a target ready response |
| tgt_stop | output | 1 | Request a target stop response |
| data_poison | output | 1 | Keep or force bad parity on the data |

## Verification
Random events sweep every combination of class, direction, write flag, bad parity, the far line and both enables. This separates cases where only one enable bit or one direction changes the reaction, such as an upstream delayed write that is dropped instead of forwarded.

Directed sequences cover the following:

- the primary-error gate on the system-error pulse;
- a delayed-write request held over several cycles before the ready strobe arrives;
- a burst versus a single phase on the dropped write;
- a clear strobe colliding with a new set.

Between these sequences, invalid cycles carry error-laden inputs to show that nothing changes.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    typedef enum logic [1:0] {
        K_PW  = 2'd0,
        K_DW  = 2'd1,
        K_DR  = 2'd2,
        K_REG = 2'd3
    } ppr_kind_e;

    localparam int STS_W   = 2;
    localparam int STS_DPD = 0;
    localparam int STS_DPE = 1;

    localparam int PIN_W     = 2;
    localparam int PIN_SPERR = 0;
    localparam int PIN_PSERR = 1;

    typedef struct packed {
        logic go;
        logic drop;
        logic trdy;
        logic stop;
        logic poison;
        logic set_dpd;
        logic set_dpe;
        logic req_sperr;
        logic req_pserr;
        logic arm_pperr;
    } ppr_act_t;

endpackage

// File: rtl/ppr_decode.sv
module ppr_decode
    import ppr_pkg::*;
(
    input  logic      valid,
    input  ppr_kind_e kind,
    input  logic      up,
    input  logic      wr,
    input  logic      bad_par,
    input  logic      burst,
    input  logic      perr_seen,
    input  logic      pri_err,
    input  logic      en_pri,
    input  logic      en_sec,
    output ppr_act_t  act
);

    always_comb begin
        act = '0;
        if (valid) begin
            act.go = 1'b1;
            unique case (kind)
                K_PW: begin
                    if (!up) begin
                        if (en_sec && perr_seen) begin
                            act.set_dpd   = 1'b1;
                            act.req_pserr = en_pri && !pri_err;
                        end
                    end else if (bad_par) begin
                        act.poison    = 1'b1;
                        act.set_dpe   = 1'b1;
                        act.req_sperr = en_sec;
                    end
                end
                K_DW: begin
                    if (!up) begin
                        if (en_sec && perr_seen) begin
                            act.set_dpd   = 1'b1;
                            act.arm_pperr = en_pri;
                        end
                    end else if (bad_par && en_sec) begin
                        act.go        = 1'b0;
                        act.drop      = 1'b1;
                        act.trdy      = 1'b1;
                        act.stop      = burst;
                        act.set_dpe   = 1'b1;
                        act.req_sperr = 1'b1;
                    end
                end
                K_DR: begin
                    if (!up && bad_par) begin
                        act.poison    = 1'b1;
                        act.set_dpe   = 1'b1;
                        act.set_dpd   = en_sec;
                        act.req_sperr = en_sec;
                    end
                end
                K_REG: begin
                    if (wr && bad_par) begin
                        act.set_dpe   = 1'b1;
                        act.req_sperr = en_sec;
                    end
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/ppr_status.sv
module ppr_status #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                sts_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                sts_o[i] <= 1'b0;
            end
        end

        // R10: a set bit without a clear strobe stays set
        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_o[i] && !clr_i[i]) |=> sts_o[i]);
    end

endmodule

// File: rtl/ppr_pulse.sv
module ppr_pulse #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pin_n_o
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_n_o[i] <= 1'b1;
            end else begin
                pin_n_o[i] <= !req_i[i];
            end
        end
    end

endmodule

// File: rtl/ppr_trdy_fsm.sv
module ppr_trdy_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic trdy_ret_i,
    output logic fire_o
);

    typedef enum logic {
        TF_IDLE = 1'b0,
        TF_HOLD = 1'b1
    } tf_state_e;

    tf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        unique case (state_q)
            TF_IDLE: begin
                if (arm_i) state_d = TF_HOLD;
            end
            TF_HOLD: begin
                if (trdy_ret_i) begin
                    fire_o  = 1'b1;
                    state_d = arm_i ? TF_HOLD : TF_IDLE;
                end
            end
            default: state_d = TF_IDLE;
        endcase
    end

    // R5: an armed request never leaves the hold state without a strobe
    p_hold_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TF_HOLD && !trdy_ret_i) |=> (state_q == TF_HOLD));

endmodule

// File: rtl/parity_resp_ctl.sv
module parity_resp_ctl
    import ppr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_valid,
    input  logic [1:0] evt_kind,
    input  logic       evt_up,
    input  logic       evt_write,
    input  logic       evt_bad_par,
    input  logic       evt_burst,
    input  logic       sec_perr_n,
    input  logic       pri_par_err,
    input  logic       per_en_pri,
    input  logic       per_en_sec,
    input  logic       pri_trdy_ret,
    input  logic [1:0] sts_w1c,
    output logic       sts_dpd,
    output logic       sts_dpe,
    output logic       sec_perr_req_n,
    output logic       pri_perr_req_n,
    output logic       pri_serr_req_n,
    output logic       xfer_go,
    output logic       xfer_drop,
    output logic       tgt_trdy,
    output logic       tgt_stop,
    output logic       data_poison
);

    ppr_act_t         act;
    logic [STS_W-1:0] sts_set;
    logic [STS_W-1:0] sts_q;
    logic [PIN_W-1:0] pin_req;
    logic [PIN_W-1:0] pin_n;
    logic             pperr_fire;
    logic             pperr_q_n;

    ppr_decode u_decode (
        .valid     (evt_valid),
        .kind      (ppr_kind_e'(evt_kind)),
        .up        (evt_up),
        .wr        (evt_write),
        .bad_par   (evt_bad_par),
        .burst     (evt_burst),
        .perr_seen (!sec_perr_n),
        .pri_err   (pri_par_err),
        .en_pri    (per_en_pri),
        .en_sec    (per_en_sec),
        .act       (act)
    );

    always_comb begin
        sts_set          = '0;
        sts_set[STS_DPD] = act.set_dpd;
        sts_set[STS_DPE] = act.set_dpe;
        pin_req            = '0;
        pin_req[PIN_SPERR] = act.req_sperr;
        pin_req[PIN_PSERR] = act.req_pserr;
    end

    ppr_status #(.W(STS_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sts_set),
        .clr_i (sts_w1c),
        .sts_o (sts_q)
    );

    ppr_pulse #(.N(PIN_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pin_req),
        .pin_n_o (pin_n)
    );

    ppr_trdy_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (act.arm_pperr),
        .trdy_ret_i (pri_trdy_ret),
        .fire_o     (pperr_fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pperr_q_n <= 1'b1;
        end else begin
            pperr_q_n <= !pperr_fire;
        end
    end

    assign sts_dpd        = sts_q[STS_DPD];
    assign sts_dpe        = sts_q[STS_DPE];
    assign sec_perr_req_n = pin_n[PIN_SPERR];
    assign pri_serr_req_n = pin_n[PIN_PSERR];
    assign pri_perr_req_n = pperr_q_n;
    assign xfer_go        = act.go;
    assign xfer_drop      = act.drop;
    assign tgt_trdy       = act.trdy;
    assign tgt_stop       = act.stop;
    assign data_poison    = act.poison;

    // R2: no decision output while no event is presented
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> !(xfer_go || xfer_drop || tgt_trdy || data_poison));

    // R6: go and drop are exclusive, stop only comes with ready
    p_drop_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_go && xfer_drop) && (!tgt_stop || tgt_trdy));

    // R3: system-error pulse requires both enables and a clean primary side
    p_serr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_serr_req_n |-> $past(per_en_pri && per_en_sec && !pri_par_err && evt_valid));

    // R11: secondary parity-error pulse follows an enabled, valid event
    p_sperr_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_perr_req_n |-> $past(per_en_sec && evt_valid));

    // R5: primary parity-error pulse follows the ready-return strobe
    p_pperr_trdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_perr_req_n |-> $past(pri_trdy_ret));

endmodule

// File: tb/parity_resp_ctl_tb.sv
`timescale 1ns/1ps
module parity_resp_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_valid, evt_up, evt_write, evt_bad_par, evt_burst;
    logic [1:0] evt_kind;
    logic       sec_perr_n, pri_par_err, per_en_pri, per_en_sec, pri_trdy_ret;
    logic [1:0] sts_w1c;
    logic       sts_dpd, sts_dpe, sec_perr_req_n, pri_perr_req_n, pri_serr_req_n;
    logic       xfer_go, xfer_drop, tgt_trdy, tgt_stop, data_poison;

    int total = 0;
    int nbad  = 0;
    bit done  = 1'b0;

    // model state
    logic m_dpd, m_dpe, m_sp_n, m_pp_n, m_ps_n, m_hold;

    always #2 clk = ~clk;

    parity_resp_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_up(evt_up), .evt_write(evt_write), .evt_bad_par(evt_bad_par),
        .evt_burst(evt_burst), .sec_perr_n(sec_perr_n), .pri_par_err(pri_par_err),
        .per_en_pri(per_en_pri), .per_en_sec(per_en_sec), .pri_trdy_ret(pri_trdy_ret),
        .sts_w1c(sts_w1c), .sts_dpd(sts_dpd), .sts_dpe(sts_dpe),
        .sec_perr_req_n(sec_perr_req_n), .pri_perr_req_n(pri_perr_req_n),
        .pri_serr_req_n(pri_serr_req_n), .xfer_go(xfer_go), .xfer_drop(xfer_drop),
        .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop), .data_poison(data_poison)
    );

    task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [1:0] k, input logic up, input logic wr);
        if (!v) return "R2";
        case (k)
            2'd0:    return up ? "R4" : "R3";
            2'd1:    return up ? "R6" : "R5";
            2'd2:    return up ? "R8" : "R7";
            default: return wr ? "R9" : "R8";
        endcase
    endfunction

    // expected {go,drop,trdy,stop,poison,dpd,dpe,sperr,pserr,arm}
    function automatic logic [9:0] ref_act(input logic v, input logic [1:0] k, input logic up,
                                           input logic wr, input logic bp, input logic bu,
                                           input logic pn, input logic pe, input logic ep,
                                           input logic es);
        logic go, dr, tr, st, po, dpd, dpe, sp, ps, arm;
        logic seen;
        seen = !pn;
        go = v; dr = 0; tr = 0; st = 0; po = 0; dpd = 0; dpe = 0; sp = 0; ps = 0; arm = 0;
        if (v) begin
            if (k == 2'd0 && !up) begin        // R3
                dpd = es && seen;
                ps  = es && ep && seen && !pe;
            end
            if (k == 2'd0 && up && bp) begin   // R4
                po = 1; dpe = 1; sp = es;
            end
            if (k == 2'd1 && !up) begin        // R5
                dpd = es && seen;
                arm = es && ep && seen;
            end
            if (k == 2'd1 && up && bp && es) begin   // R6
                go = 0; dr = 1; tr = 1; st = bu; dpe = 1; sp = 1;
            end
            if (k == 2'd2 && !up && bp) begin  // R7
                po = 1; dpe = 1; dpd = es; sp = es;
            end
            if (k == 2'd3 && wr && bp) begin   // R9
                dpe = 1; sp = es;
            end
        end
        return {go, dr, tr, st, po, dpd, dpe, sp, ps, arm};
    endfunction

    task automatic step(input logic v, input logic [1:0] k, input logic up, input logic wr,
                        input logic bp, input logic bu, input logic pn, input logic pe,
                        input logic ep, input logic es, input logic tr, input logic [1:0] clr);
        logic [9:0] e;
        string rq;
        // registered outputs from the previous edge
        chk("R10", "sts_dpd", 8'(sts_dpd), 8'(m_dpd));
        chk("R10", "sts_dpe", 8'(sts_dpe), 8'(m_dpe));
        chk("R11", "sec_perr_req_n", 8'(sec_perr_req_n), 8'(m_sp_n));
        chk("R3",  "pri_serr_req_n", 8'(pri_serr_req_n), 8'(m_ps_n));
        chk("R5",  "pri_perr_req_n", 8'(pri_perr_req_n), 8'(m_pp_n));
        evt_valid = v; evt_kind = k; evt_up = up; evt_write = wr; evt_bad_par = bp;
        evt_burst = bu; sec_perr_n = pn; pri_par_err = pe; per_en_pri = ep;
        per_en_sec = es; pri_trdy_ret = tr; sts_w1c = clr;
        #1;
        e  = ref_act(v, k, up, wr, bp, bu, pn, pe, ep, es);
        rq = tag_of(v, k, up, wr);
        chk(rq, "decision {go,drop,trdy,stop,poison}",
            8'({xfer_go, xfer_drop, tgt_trdy, tgt_stop, data_poison}), 8'(e[9:5]));
        @(posedge clk);
        m_pp_n = !(m_hold && tr);
        m_hold = e[0] || (m_hold && !tr);
        m_dpd  = e[4] || (m_dpd && !clr[0]);
        m_dpe  = e[3] || (m_dpe && !clr[1]);
        m_sp_n = !e[2];
        m_ps_n = !e[1];
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 2'b00);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0;
        evt_valid = 0; evt_kind = 0; evt_up = 0; evt_write = 0; evt_bad_par = 0;
        evt_burst = 0; sec_perr_n = 1; pri_par_err = 0; per_en_pri = 0; per_en_sec = 0;
        pri_trdy_ret = 0; sts_w1c = 0;
        m_dpd = 0; m_dpe = 0; m_sp_n = 1; m_pp_n = 1; m_ps_n = 1; m_hold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "status", 8'({sts_dpd, sts_dpe}), 8'd0);
        chk("R1", "requests", 8'({sec_perr_req_n, pri_perr_req_n, pri_serr_req_n}), 8'h7);
        chk("R1", "decision", 8'({xfer_go, xfer_drop, tgt_trdy, tgt_stop, data_poison}), 8'd0);

        // R2: invalid cycle with every error input active
        step(0, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 2'b00);
        idle(1);
        // R3: system error only with a clean primary side
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 2'b00);
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 2'b00);
        idle(1);
        // R10: clear both, then set and clear collide
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 2'b11);
        step(1, 2, 0, 0, 1, 0, 1, 0, 1, 1, 0, 2'b11);
        idle(1);
        // R5: arm, hold three cycles, then ready strobe
        step(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 2'b00);
        idle(3);
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 2'b00);
        idle(2);
        // R6: dropped write, single phase and burst, then enable clear
        step(1, 1, 1, 0, 1, 0, 1, 0, 0, 1, 0, 2'b00);
        step(1, 1, 1, 0, 1, 1, 1, 0, 0, 1, 0, 2'b00);
        step(1, 1, 1, 0, 1, 1, 1, 0, 1, 0, 0, 2'b00);
        // R4, R7, R8, R9 directed
        step(1, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 2'b11);
        step(1, 2, 0, 0, 1, 0, 1, 0, 0, 0, 0, 2'b11);
        step(1, 2, 1, 0, 1, 1, 0, 1, 1, 1, 0, 2'b11);
        step(1, 3, 0, 0, 1, 0, 0, 0, 1, 1, 0, 2'b11);
        step(1, 3, 1, 1, 1, 0, 1, 0, 1, 1, 0, 2'b00);
        idle(2);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] clr;
            clr = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
            step(($urandom_range(0, 99) < 85), 2'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 2) == 0), clr);
        end
        idle(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, nbad);
        $finish;
    end

endmodule